// File: doc/BRIEF.md
# Nibble-Bus Fetch Sequencer

This block is the processor-side master of one shared 4-bit bus. A 12-bit program address, an 8-bit instruction and a 4-bit write datum all travel over that bus. The block divides time into machine cycles of exactly eight clocks that follow one another with no gap. In each cycle it sends the fetch address as three nibbles and reads the instruction byte back as two nibbles. The last three clocks are left for a data transfer. A program-memory select covers the whole fetch window, and no data-memory select can be active during that window. Instruction code therefore always comes from program memory.

The block holds its own fetch address. That address advances by one after every byte fetched, and it can be reloaded at the end of any cycle. The block classifies each first byte. For an instruction of two bytes it flags that a second cycle is needed, and it places the second byte in a separate output register. Downstream execution logic reads the two opcode registers and the cycle flags. It may request a nibble write into one of several data-memory banks for the transfer window of the current cycle.

Top module: `nibble_fetch_seq`

## Requirements
- R1: The `phase` output counts 0,1,...,7,0,... with one step per clock and no idle clock. It is 0 while reset is held and in the first clock after reset is released.
- R2: `sync` is high in phase 7 and low in every other phase.
- R3: In phases 0, 1 and 2 the bus is driven (`bus_oe`=1) with address bits [3:0], [7:4] and [11:8] respectively.
- R4: In phases 3 and 4 the bus is released. The nibble on `bus_i` at the end of phase 3 is the opcode's upper nibble, and the nibble at the end of phase 4 is its lower nibble. The assembled byte appears on an opcode output from phase 5 onward.
- R5: `prog_sel` is high in phases 0 to 4 and low in phases 5 to 7. Every bit of `data_sel` is low whenever `prog_sel` is high.
- R6: A first byte needs a second byte when its upper nibble is 1, 4, 5 or 7, or when its upper nibble is 2 and bit 0 is 0. In phases 5 to 7 of that first cycle, `need_second` is high. The next cycle fetches the following byte into `op_second` and leaves `op_first` unchanged.
- R7: `instr_done` is high in phases 5 to 7 of a cycle that completes an instruction: the cycle of a one-byte instruction, or the second cycle of a two-byte one. It is low at all other times. `need_second` and `instr_done` are never high together.
- R8: `wr_req` is sampled at the end of phase 4. If it is set, then in phases 5 to 7 the bus is driven with the `wr_data` sampled at that edge, and only `data_sel` bit `wr_bank` is high. If it is clear, the bus is released and `data_sel` stays all zero in those phases.
- R9: `pc` increments by one at the end of phase 4 of every cycle, and it wraps from 0xFFF to 0x000.
- R10: When `pc_ld` is high at the end of phase 7, the next cycle fetches from `pc_ld_addr`.
- R11: While reset is held, `pc`, `op_first` and `op_second` are 0, and `need_second`, `instr_done` and `data_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_ld | input | 1 | Load the fetch address at the end of phase 7 |
| pc_ld_addr | input | 12 | Address to load |
| wr_req | input | 1 | Request a nibble write in this cycle's transfer window |
| wr_data | input | 4 | Nibble to write |
| wr_bank | input | 2 | Data-memory bank to select for the write |
| bus_i | input | 4 | Value present on the shared bus |
| bus_o | output | 4 | Value this block drives on the bus |
| bus_oe | output | 1 | Bus driver enable |
| prog_sel | output | 1 | Program-memory select |
| data_sel | output | 4 | Data-memory bank selects, one-hot or zero |
| phase | output | 3 | Position within the 8-clock machine cycle |
| sync | output | 1 | Frame alignment strobe in the last phase |
| pc | output | 12 | Current fetch address |
| op_first | output | 8 | First instruction byte |
| op_second | output | 8 | Second byte of a two-byte instruction |
| need_second | output | 1 | Current instruction needs another cycle |
| instr_done | output | 1 | Instruction complete in this cycle |

## Verification
The assertions assume a well-behaved environment. Reset is held long enough for its values to settle, `wr_bank` addresses an existing bank, and `pc_ld` and `wr_req` are changed only away from the edges that sample them. The bench meets these assumptions. It drives every request on the falling edge of the phase whose closing edge samples it, and it removes each request one phase later. The bench memory model drives the bus only when `bus_oe` is low. It returns bytes for the address it assembled from the three address nibbles, so a wrong nibble order shows up as a wrong opcode.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

    localparam int NIB_W     = 4;
    localparam int ADDR_W    = 12;
    localparam int FRAME_LEN = 8;
    localparam int N_BANKS   = 4;

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int PH_W      = $clog2(FRAME_LEN);
    localparam int BANK_W    = $clog2(N_BANKS);
    localparam int BYTE_W    = 2 * NIB_W;

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BANK_W-1:0] bank_t;

    // phase landmarks inside one machine cycle
    localparam phase_t PH_HI  = phase_t'(ADDR_NIBS);
    localparam phase_t PH_LO  = phase_t'(ADDR_NIBS + 1);
    localparam phase_t PH_XF  = phase_t'(ADDR_NIBS + 2);
    localparam phase_t PH_END = phase_t'(FRAME_LEN - 1);

    typedef enum logic {
        CYC_FIRST  = 1'b0,
        CYC_SECOND = 1'b1
    } cyc_kind_t;

    typedef struct packed {
        logic  pend;
        nib_t  data;
        bank_t bank;
    } wr_slot_t;

    // classification of a first byte: does it carry a trailing byte
    function automatic logic needs_two_bytes(byte_t op);
        logic r;
        case (op[BYTE_W-1:NIB_W])
            4'h1, 4'h4, 4'h5, 4'h7: r = 1'b1;
            4'h2:                   r = ~op[0];
            default:                r = 1'b0;
        endcase
        return r;
    endfunction

    // address nibble sent in a given phase, low nibble first
    function automatic nib_t addr_nib(addr_t a, phase_t p);
        nib_t r = '0;
        for (int i = 0; i < ADDR_NIBS; i++) begin
            if (p == phase_t'(i)) r = a[i*NIB_W +: NIB_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/nfs_phase_gen.sv
module nfs_phase_gen
    import nfs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   sync
);

    always_ff @(posedge clk) begin
        if (rst)                  phase <= '0;
        else if (phase == PH_END) phase <= '0;
        else                      phase <= phase + phase_t'(1);
    end

    assign sync = (phase == PH_END);

    // R2: the frame strobe is followed by the start of a new frame
    a_r2_sync_then_start: assert property (@(posedge clk) disable iff (rst)
        sync |=> (phase == '0));

endmodule

// File: rtl/nfs_addr_path.sv
module nfs_addr_path
    import nfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  phase_t             phase,
    input  logic               pc_ld,
    input  addr_t              pc_ld_addr,
    input  logic               wr_req,
    input  nib_t               wr_data,
    input  bank_t              wr_bank,
    output addr_t              pc,
    output nib_t               bus_o,
    output logic               bus_oe,
    output logic [N_BANKS-1:0] data_sel
);

    wr_slot_t slot;
    logic     in_addr;
    logic     in_xfer;
    logic     xfer_drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            slot <= '0;
        end else begin
            if (phase == PH_LO) begin
                pc   <= pc + addr_t'(1);
                slot <= '{pend: wr_req, data: wr_data, bank: wr_bank};
            end
            if (phase == PH_END) begin
                slot.pend <= 1'b0;
                if (pc_ld) pc <= pc_ld_addr;
            end
        end
    end

    assign in_addr    = (phase < PH_HI);
    assign in_xfer    = (phase >= PH_XF);
    assign xfer_drive = in_xfer & slot.pend;

    assign bus_oe = in_addr | xfer_drive;
    assign bus_o  = in_addr    ? addr_nib(pc, phase) :
                    xfer_drive ? slot.data : '0;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign data_sel[b] = xfer_drive & (slot.bank == bank_t'(b));
    end

    // R9: one step per fetched byte, observed right after the low-nibble capture
    a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_XF && !$past(rst)) |-> (pc == $past(pc) + addr_t'(1)));

    // R8: at most one data bank selected
    a_r8_bank_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(data_sel));

    // R4: the bus stays released while the memory returns the opcode
    a_r4_bus_released: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HI || phase == PH_LO) |-> !bus_oe);

endmodule

// File: rtl/nfs_op_capture.sv
module nfs_op_capture
    import nfs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    input  nib_t   bus_i,
    output byte_t  op_first,
    output byte_t  op_second,
    output logic   need_second,
    output logic   instr_done
);

    nib_t      hi_q;
    cyc_kind_t kind;
    logic      long_op;
    logic      exec;

    assign long_op = needs_two_bytes(op_first);
    assign exec    = (phase >= PH_XF);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q      <= '0;
            op_first  <= '0;
            op_second <= '0;
            kind      <= CYC_FIRST;
        end else begin
            if (phase == PH_HI) hi_q <= bus_i;
            if (phase == PH_LO) begin
                if (kind == CYC_FIRST) op_first  <= {hi_q, bus_i};
                else                   op_second <= {hi_q, bus_i};
            end
            if (phase == PH_END)
                kind <= (kind == CYC_FIRST && long_op) ? CYC_SECOND : CYC_FIRST;
        end
    end

    assign need_second = exec & (kind == CYC_FIRST) & long_op;
    assign instr_done  = exec & ((kind == CYC_SECOND) | ~long_op);

    // R7: the two cycle flags exclude each other
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(need_second && instr_done));

    // R6: the first byte is held while the second byte is being fetched
    a_r6_first_held: assert property (@(posedge clk) disable iff (rst)
        (need_second && phase == PH_END) |=> $stable(op_first));

endmodule

// File: rtl/nibble_fetch_seq.sv
module nibble_fetch_seq
    import nfs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pc_ld,
    input  logic [ADDR_W-1:0]    pc_ld_addr,
    input  logic                 wr_req,
    input  logic [NIB_W-1:0]     wr_data,
    input  logic [BANK_W-1:0]    wr_bank,
    input  logic [NIB_W-1:0]     bus_i,
    output logic [NIB_W-1:0]     bus_o,
    output logic                 bus_oe,
    output logic                 prog_sel,
    output logic [N_BANKS-1:0]   data_sel,
    output logic [PH_W-1:0]      phase,
    output logic                 sync,
    output logic [ADDR_W-1:0]    pc,
    output logic [BYTE_W-1:0]    op_first,
    output logic [BYTE_W-1:0]    op_second,
    output logic                 need_second,
    output logic                 instr_done
);

    nfs_phase_gen i_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .sync  (sync)
    );

    nfs_addr_path i_addr (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .pc_ld      (pc_ld),
        .pc_ld_addr (pc_ld_addr),
        .wr_req     (wr_req),
        .wr_data    (wr_data),
        .wr_bank    (wr_bank),
        .pc         (pc),
        .bus_o      (bus_o),
        .bus_oe     (bus_oe),
        .data_sel   (data_sel)
    );

    nfs_op_capture i_cap (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .bus_i       (bus_i),
        .op_first    (op_first),
        .op_second   (op_second),
        .need_second (need_second),
        .instr_done  (instr_done)
    );

    // program memory owns the whole fetch window
    assign prog_sel = (phase <= PH_LO);

    // R1: the frame counter never stalls or skips
    a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase == $past(phase) + phase_t'(1)));

    // R5: no data bank can be selected while code is fetched
    a_r5_fetch_exclusive: assert property (@(posedge clk) disable iff (rst)
        prog_sel |-> (data_sel == '0));

endmodule

// File: tb/test_nibble_fetch_seq.sv
`timescale 1ns/1ps
module test_nibble_fetch_seq;
    import nfs_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pc_ld = 1'b0;
    logic [11:0] pc_ld_addr = '0;
    logic        wr_req = 1'b0;
    logic [3:0]  wr_data = '0;
    logic [1:0]  wr_bank = '0;
    logic [3:0]  bus_i;
    logic [3:0]  bus_o;
    logic        bus_oe;
    logic        prog_sel;
    logic [3:0]  data_sel;
    logic [2:0]  phase;
    logic        sync;
    logic [11:0] pc;
    logic [7:0]  op_first;
    logic [7:0]  op_second;
    logic        need_second;
    logic        instr_done;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    nibble_fetch_seq i_nibble_fetch_seq (
        .clk(clk), .rst(rst), .pc_ld(pc_ld), .pc_ld_addr(pc_ld_addr),
        .wr_req(wr_req), .wr_data(wr_data), .wr_bank(wr_bank),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .prog_sel(prog_sel),
        .data_sel(data_sel), .phase(phase), .sync(sync), .pc(pc),
        .op_first(op_first), .op_second(op_second),
        .need_second(need_second), .instr_done(instr_done)
    );

    // byte-wide program memory model on the nibble bus
    logic [7:0]  mem [256];
    logic [11:0] seen = '0;

    always @(posedge clk) begin
        if (!rst && phase < 3'd3) seen[int'(phase)*4 +: 4] <= bus_o;
    end

    assign bus_i = bus_oe        ? bus_o :
                   (phase == 3'd3) ? mem[seen[7:0]][7:4] :
                   (phase == 3'd4) ? mem[seen[7:0]][3:0] : 4'hF;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one machine cycle, starting just before the falling edge of phase 0
    task automatic frame(input logic [11:0] a, input logic [7:0] e1,
                         input logic [7:0] e2, input bit chk2,
                         input bit edone, input bit esec,
                         input bit wr, input logic [3:0] wd, input logic [1:0] wb,
                         input bit ld, input logic [11:0] la);
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            if (p == 0) pc_ld = 1'b0;
            chk("R1", phase, p, "phase");
            chk("R2", sync, (p == 7), "sync");
            chk("R5", prog_sel, (p <= 4), "prog_sel");
            if (p <= 4) chk("R5", data_sel, 4'h0, "data_sel in fetch");
            if (p < 3) begin
                chk("R3", bus_oe, 1, "addr drive");
                chk("R3", bus_o, a[p*4 +: 4], "addr nibble");
            end
            if (p == 3 || p == 4) chk("R4", bus_oe, 0, "released");
            if (p == 4) begin
                wr_req = wr; wr_data = wd; wr_bank = wb;
            end
            if (p == 5) begin
                wr_req = 1'b0;
                chk("R4", op_first, e1, "op_first");
                if (chk2) chk("R6", op_second, e2, "op_second");
                chk("R6", need_second, esec, "need_second");
                chk("R7", instr_done, edone, "instr_done");
                chk("R9", pc, 12'(a + 12'd1), "pc step/wrap");
            end
            if (p >= 5) begin
                chk("R8", bus_oe, wr, "xfer drive");
                chk("R8", data_sel, wr ? (4'b0001 << wb) : 4'b0000, "data_sel");
                if (wr) chk("R8", bus_o, wd, "write nibble");
            end
            if (p == 7) begin
                pc_ld = ld; pc_ld_addr = la;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11", phase, 0, "phase in reset");
        chk("R11", pc, 0, "pc in reset");
        chk("R11", op_first, 0, "op_first in reset");
        chk("R11", op_second, 0, "op_second in reset");
        chk("R11", {need_second, instr_done}, 0, "flags in reset");
        chk("R11", data_sel, 0, "data_sel in reset");
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic t_short();   // R4 R7: one-byte instruction at 0x000
        frame(12'h000, 8'hA3, 8'h00, 0, 1, 0, 0, 4'h0, 2'd0, 0, 12'h0);
    endtask

    task automatic t_long();    // R6: two-byte pair at 0x001
        frame(12'h001, 8'h12, 8'h00, 0, 0, 1, 0, 4'h0, 2'd0, 0, 12'h0);
        frame(12'h002, 8'h12, 8'h34, 1, 1, 0, 0, 4'h0, 2'd0, 0, 12'h0);
    endtask

    task automatic t_write();   // R8 write then idle, R10 load to 0xFFF
        frame(12'h003, 8'h60, 8'h00, 0, 1, 0, 1, 4'hB, 2'd2, 0, 12'h0);
        frame(12'h004, 8'h30, 8'h00, 0, 1, 0, 0, 4'h0, 2'd0, 1, 12'hFFF);
    endtask

    task automatic t_wrap();    // R9 wrap inside a two-byte instruction
        frame(12'hFFF, 8'h20, 8'h00, 0, 0, 1, 0, 4'h0, 2'd0, 0, 12'h0);
        frame(12'h000, 8'h20, 8'hA3, 1, 1, 0, 0, 4'h0, 2'd0, 1, 12'h5C0);
    endtask

    task automatic t_mixed();   // R6 odd 0x2x short, 0x7x long with write in 2nd cycle
        frame(12'h5C0, 8'h21, 8'h00, 0, 1, 0, 0, 4'h0, 2'd0, 0, 12'h0);
        frame(12'h5C1, 8'h7E, 8'h00, 0, 0, 1, 0, 4'h0, 2'd0, 0, 12'h0);
        frame(12'h5C2, 8'h7E, 8'h5D, 1, 1, 0, 1, 4'h5, 2'd0, 0, 12'h0);
        frame(12'h5C3, 8'h8F, 8'h00, 0, 1, 0, 1, 4'h9, 2'd3, 0, 12'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hF0;
        mem[8'h00] = 8'hA3; mem[8'h01] = 8'h12; mem[8'h02] = 8'h34;
        mem[8'h03] = 8'h60; mem[8'h04] = 8'h30; mem[8'hFF] = 8'h20;
        mem[8'hC0] = 8'h21; mem[8'hC1] = 8'h7E; mem[8'hC2] = 8'h5D;
        mem[8'hC3] = 8'h8F;
        repeat (3) @(posedge clk);
        t_reset();
        t_short();
        t_long();
        t_write();
        t_wrap();
        t_mixed();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule